// File: doc/BRIEF.md
# I2C write-only slave with subaddress acknowledge

This block is the receive-only two-wire serial front end of a cascadable display driver. It samples the clock and data lines into the system clock domain and finds START and STOP conditions. It shifts in bytes and compares the first byte of each transfer with a 7-bit bus address. The top six address bits are fixed, and the lowest address bit comes from a strap pin. The slave never sends data. Its only drive on the data line is the acknowledge pull-down.

Several slaves may share one bus address. They all acknowledge the address byte and the command bytes at the same moment. Once the command phase ends, only the slave whose 3-bit strap pins equal the subaddress last loaded by a device-select command acknowledges the display bytes, and only that slave passes them downstream. The most significant bit of each command byte says whether another command follows. The first command with that bit clear is the last command, and every later byte of the transfer is display data.

Each accepted byte leaves through a one-cycle strobe that carries a command/data tag. When the downstream logic reports busy at a byte boundary, the slave holds the clock line low until busy clears, and no data is lost.

Top module: `i2cw_slave`

## Requirements
- R1: The first byte after a START is acknowledged (data line held low during the 9th clock) only when its bits [7:2] are 011100, bit [1] equals `sa0` and bit [0] (read/write) is 0.
- R2: After an address byte that fails R1, including any byte whose bit [0] is 1, the slave drives neither line and raises no strobe for any byte until the next START.
- R3: In an addressed transfer, every command byte is acknowledged whatever the level on `a_pins`.
- R4: When the slave acknowledges, the data line stays low for the whole high period of the acknowledge clock.
- R5: The byte after the address is a command. A command with bit 7 = 1 is followed by another command. A command with bit 7 = 0 is the last one, and all later bytes of the transfer are display data, even if their bit 7 is 1.
- R6: A command byte whose bits [6:3] are 1100 loads its bits [2:0] into the internal subaddress. The subaddress is 0 after reset and keeps its value across transfers.
- R7: A display-data byte is acknowledged and strobed only when `a_pins` equals the internal subaddress.
- R8: If `busy` is high when the 8th clock of a byte falls, `scl_pull` holds the clock line low until `busy` goes low. The acknowledge clock then proceeds, and the byte is delivered intact.
- R9: The acknowledge pull-down is released after the falling clock edge that ends the acknowledge clock, within the synchronizer latency.
- R10: Each accepted command or data byte gives a one-cycle `rx_valid` with the byte on `rx_data`. `rx_is_cmd` is 1 for a command and 0 for data. The address byte is never strobed.
- R11: A repeated START in the middle of a byte discards the partial byte and restarts address reception. After a STOP, bytes clocked without a new START are not acknowledged.
- R12: While reset is held, `sda_pull`, `scl_pull` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| sa0 | input | 1 | Strap selecting the lowest bus address bit |
| a_pins | input | SUB_W | Hardware subaddress straps |
| busy | input | 1 | Downstream logic cannot accept a byte yet |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| scl_pull | output | 1 | Open-drain pull-down enable for the clock line (stretch) |
| rx_valid | output | 1 | One-cycle strobe for an accepted byte |
| rx_data | output | 8 | Accepted byte |
| rx_is_cmd | output | 1 | 1 when the strobed byte is a command, 0 for display data |

## Verification
The bench builds the block with its default parameters: a 3-bit subaddress, a two-stage line synchronizer and the 011100 address prefix. With a 3-bit subaddress, all 64 pairs of strap value and loaded subaddress fit in one sweep, and every 7-bit address can be tried against both `sa0` levels, so the acknowledge rules are checked exhaustively rather than by sampling. Directed sequences cover the change from command to data phase, a stretched byte, an aborted byte and bytes clocked after a STOP.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0]             raw;
  logic [LINES-1:0][STAGES-1:0] chain_q;
  logic                         scl_s;
  logic                         scl_q;
  logic                         sda_q;

  assign raw = {sda_in, scl_in};

  // one synchronizer chain per bus line; idle bus level is high
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= '1;
      else        chain_q[g] <= {chain_q[g][STAGES-2:0], raw[g]};
    end
  end

  assign scl_s = chain_q[0][STAGES-1];
  assign sda_s = chain_q[1][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s && !scl_q;
  assign scl_fall  = !scl_s &&  scl_q;
  assign start_det =  scl_s &&  scl_q &&  sda_q && !sda_s;
  assign stop_det  =  scl_s &&  scl_q && !sda_q &&  sda_s;
endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
  import i2cw_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sa0,
  input  logic       busy,
  input  logic       ack_ok,
  output logic       sda_pull,
  output logic       scl_pull,
  output logic       addr_hit,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  rx_state_e              state_q, state_d;
  logic [BYTE_BITS-1:0]   shreg_q, shreg_d;
  logic [CNT_W-1:0]       bitcnt_q, bitcnt_d;
  logic                   first_q, first_d;
  logic                   ack_q, ack_d;
  logic                   boundary;
  logic                   addr_match;

  assign boundary   = scl_fall && (bitcnt_q == CNT_W'(BYTE_BITS));
  assign addr_match = (shreg_q[7:2] == ADDR_HI) && (shreg_q[1] == sa0) && !shreg_q[0];

  always_comb begin
    state_d   = state_q;
    shreg_d   = shreg_q;
    bitcnt_d  = bitcnt_q;
    first_d   = first_q;
    ack_d     = ack_q;
    addr_hit  = 1'b0;
    byte_done = 1'b0;
    case (state_q)
      ST_SHIFT: begin
        if (scl_rise && (bitcnt_q < CNT_W'(BYTE_BITS))) begin
          shreg_d  = {shreg_q[BYTE_BITS-2:0], sda_s};
          bitcnt_d = bitcnt_q + 1'b1;
        end
        if (boundary) begin
          if (first_q) begin
            if (addr_match) begin
              addr_hit = 1'b1;
              first_d  = 1'b0;
              ack_d    = 1'b1;
              state_d  = busy ? ST_HOLD : ST_ACK;
            end else begin
              state_d  = ST_SKIP;
            end
          end else begin
            byte_done = 1'b1;
            ack_d     = ack_ok;
            state_d   = busy ? ST_HOLD : ST_ACK;
          end
        end
      end
      ST_HOLD: begin
        if (!busy) state_d = ST_ACK;
      end
      ST_ACK: begin
        if (scl_fall) begin
          ack_d    = 1'b0;
          bitcnt_d = '0;
          state_d  = ST_SHIFT;
        end
      end
      default: ;
    endcase
    // bus conditions override everything; START wins over STOP
    if (start_det) begin
      state_d   = ST_SHIFT;
      first_d   = 1'b1;
      bitcnt_d  = '0;
      ack_d     = 1'b0;
      addr_hit  = 1'b0;
      byte_done = 1'b0;
    end else if (stop_det) begin
      state_d   = ST_IDLE;
      bitcnt_d  = '0;
      ack_d     = 1'b0;
      addr_hit  = 1'b0;
      byte_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      first_q  <= 1'b1;
      ack_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      shreg_q  <= shreg_d;
      bitcnt_q <= bitcnt_d;
      first_q  <= first_d;
      ack_q    <= ack_d;
    end
  end

  assign sda_pull = ack_q;
  assign scl_pull = (state_q == ST_HOLD);
  assign rx_byte  = shreg_q;

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && !scl_fall && !start_det && !stop_det) |=> sda_pull);

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && scl_fall && !start_det && !stop_det) |=> !sda_pull);

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && busy && !start_det && !stop_det) |=> scl_pull);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP && !start_det) |=> (!sda_pull && !byte_done));
endmodule

// File: rtl/i2cw_cmd_track.sv
module i2cw_cmd_track #(
  parameter int               SUB_W    = 3,
  parameter logic [6-SUB_W:0] SEL_CODE = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_hit,
  input  logic             byte_done,
  input  logic [7:0]       byte_in,
  output logic             cmd_ph,
  output logic [SUB_W-1:0] sub_q
);
  logic             cmd_q, cmd_d;
  logic [SUB_W-1:0] sub_d;
  logic             cmd_byte;

  assign cmd_byte = byte_done && cmd_q;

  always_comb begin
    cmd_d = cmd_q;
    sub_d = sub_q;
    if (cmd_byte && (byte_in[6:SUB_W] == SEL_CODE)) sub_d = byte_in[SUB_W-1:0];
    if (cmd_byte && !byte_in[7])                    cmd_d = 1'b0;
    if (addr_hit)                                   cmd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      sub_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      sub_q <= sub_d;
    end
  end

  assign cmd_ph = cmd_q;

  // R5
  last_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cmd_ph && !byte_in[7] && !addr_hit) |=> !cmd_ph);

  // R6
  sub_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cmd_ph && (byte_in[6:SUB_W] == SEL_CODE))
      |=> (sub_q == $past(byte_in[SUB_W-1:0])));
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         SUB_W       = 3,
  parameter logic [5:0] ADDR_HI     = 6'b011100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             sa0,
  input  logic [SUB_W-1:0] a_pins,
  input  logic             busy,
  output logic             sda_pull,
  output logic             scl_pull,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_is_cmd
);
  localparam logic [6-SUB_W:0] SEL_CODE = {2'b11, {(5-SUB_W){1'b0}}};

  logic [1:0]       rst_pipe;
  logic             rst_n_i;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             addr_hit, byte_done, ack_ok, cmd_ph, strobe_en;
  logic [7:0]       rx_byte;
  logic [SUB_W-1:0] sub_q;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cw_rx_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sa0       (sa0),
    .busy      (busy),
    .ack_ok    (ack_ok),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull),
    .addr_hit  (addr_hit),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  i2cw_cmd_track #(.SUB_W(SUB_W), .SEL_CODE(SEL_CODE)) u_track (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .addr_hit  (addr_hit),
    .byte_done (byte_done),
    .byte_in   (rx_byte),
    .cmd_ph    (cmd_ph),
    .sub_q     (sub_q)
  );

  // commands go to every addressed slave, data only to the selected one
  assign ack_ok    = cmd_ph || (sub_q == a_pins);
  assign strobe_en = byte_done && ack_ok;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_is_cmd <= 1'b0;
    end else begin
      rx_valid <= strobe_en;
      if (strobe_en) begin
        rx_data   <= rx_byte;
        rx_is_cmd <= cmd_ph;
      end
    end
  end

  // R7
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (byte_done && !cmd_ph && (sub_q != a_pins)) |=> (!sda_pull && !rx_valid));

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_valid |=> !rx_valid);

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_i |-> (!sda_pull && !scl_pull && !rx_valid));
endmodule

// File: tb/i2cw_slave_test.sv
module i2cw_slave_test;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, sa0, busy;
  logic [2:0] a_pins;
  logic       sda_pull, scl_pull, rx_valid, rx_is_cmd;
  logic [7:0] rx_data;
  wire        scl_line = scl_m & ~scl_pull;
  wire        sda_line = sda_m & ~sda_pull;

  int n_chk = 0;
  int n_bad = 0;
  int strobes = 0;
  logic [7:0] last_d = '0;
  logic       last_c = 1'b0;

  always #5 clk = ~clk;

  i2cw_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .sa0(sa0), .a_pins(a_pins), .busy(busy),
    .sda_pull(sda_pull), .scl_pull(scl_pull),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_cmd(rx_is_cmd)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      strobes <= strobes + 1;
      last_d  <= rx_data;
      last_c  <= rx_is_cmd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait (scl_line); wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait (scl_line); wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait (scl_line); wait_q(2 * Q);
      scl_m = 1'b0; wait_q(Q);
    end
  endtask

  // sends one byte plus the acknowledge clock; returns 1 when acknowledged
  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a0, a1;
    send_bits(b, 8);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait (scl_line);
    @(negedge clk); a0 = sda_line;
    wait_q(2 * Q - 1); a1 = sda_line;
    scl_m = 1'b0;
    ack = !a0;
    if (!a0) chk(a1 == a0, "R4 ack low through high", int'(a1), int'(a0));
    wait_q(Q);
    if (ack) chk(!sda_pull, "R9 ack released", int'(sda_pull), 0);
  endtask

  initial begin
    bit ack;
    int s0;
    scl_m = 1'b1; sda_m = 1'b1; sa0 = 1'b0; busy = 1'b0; a_pins = 3'd0;
    rst_n = 1'b0;
    wait_q(4);
    // R12 reset state
    chk(!sda_pull && !scl_pull && !rx_valid, "R12 reset outputs", int'({sda_pull, scl_pull, rx_valid}), 0);
    rst_n = 1'b1;
    wait_q(4);

    // R1 / R2: every address against both strap levels
    for (int sv = 0; sv < 2; sv++) begin
      sa0 = sv[0];
      for (int a = 0; a < 128; a++) begin
        bit exp;
        exp = (a[6:1] == 6'b011100) && (a[0] == sv[0]);
        bus_start();
        send_byte({a[6:0], 1'b0}, ack);
        chk(ack == exp, exp ? "R1 address ack" : "R2 address ignored", int'(ack), int'(exp));
        bus_stop();
      end
    end

    // R2: read bit set gives no acknowledge
    sa0 = 1'b0;
    bus_start();
    send_byte(8'b0111_0001, ack);
    chk(!ack, "R2 read request ignored", int'(ack), 0);
    bus_stop();

    // R2: bytes after a foreign address are neither acknowledged nor strobed
    s0 = strobes;
    bus_start();
    send_byte(8'b0111_0010, ack);
    chk(!ack, "R2 foreign address", int'(ack), 0);
    send_byte(8'h80, ack); chk(!ack, "R2 later byte 1", int'(ack), 0);
    send_byte(8'h00, ack); chk(!ack, "R2 later byte 2", int'(ack), 0);
    send_byte(8'h55, ack); chk(!ack, "R2 later byte 3", int'(ack), 0);
    bus_stop();
    chk(strobes == s0, "R2 no strobes", strobes - s0, 0);

    // R3 / R6 / R10: commands acked whatever the straps; device-select loads 3
    a_pins = 3'd5;
    s0 = strobes;
    bus_start();
    send_byte(8'b0111_0000, ack);
    send_byte(8'b1_1100_011, ack);
    chk(ack, "R3 device-select acked", int'(ack), 1);
    chk(last_d == 8'hE3 && last_c, "R10 command strobe", int'({last_c, last_d}), 'h1E3);
    send_byte(8'h40, ack);
    chk(ack, "R3 last command acked", int'(ack), 1);
    chk(last_d == 8'h40 && last_c, "R10 last command strobe", int'({last_c, last_d}), 'h140);
    send_byte(8'hA5, ack);
    chk(!ack, "R7 data not for this slave", int'(ack), 0);
    bus_stop();
    chk(strobes - s0 == 2, "R10 strobe count", strobes - s0, 2);

    // R7 / R6: every subaddress against every strap value
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] d;
        bit exp;
        d = {s[2:0], p[2:0], 2'b10};
        exp = (s == p);
        a_pins = p[2:0];
        bus_start();
        send_byte(8'b0111_0000, ack);
        send_byte({1'b0, 4'b1100, s[2:0]}, ack);
        chk(ack, "R3 select acked", int'(ack), 1);
        s0 = strobes;
        send_byte(d, ack);
        chk(ack == exp, "R7 data ack by subaddress", int'(ack), int'(exp));
        chk((strobes - s0) == int'(exp), "R7 data strobe", strobes - s0, int'(exp));
        if (exp) chk(last_d == d && !last_c, "R10 data strobe", int'({last_c, last_d}), int'(d));
        bus_stop();
      end
    end

    // R6: subaddress (now 7) persists into a new transfer
    a_pins = 3'd7;
    bus_start();
    send_byte(8'b0111_0000, ack);
    send_byte(8'h00, ack);
    send_byte(8'h3A, ack);
    chk(ack, "R6 subaddress kept", int'(ack), 1);
    bus_stop();

    // R5: continuation chain, then a data byte with bit 7 set
    bus_start();
    send_byte(8'b0111_0000, ack);
    send_byte(8'h80, ack);
    chk(ack && last_c, "R5 continued command", int'({ack, last_c}), 3);
    send_byte(8'h81, ack);
    send_byte(8'h01, ack);
    chk(ack && last_c, "R5 final command", int'({ack, last_c}), 3);
    send_byte(8'hFF, ack);
    chk(ack && !last_c && last_d == 8'hFF, "R5 data after last command", int'({last_c, last_d}), 'hFF);
    a_pins = 3'd2;
    send_byte(8'h90, ack);
    chk(!ack, "R5 still data phase", int'(ack), 0);
    a_pins = 3'd7;
    bus_stop();

    // R8: busy at the byte boundary stretches the clock
    bus_start();
    send_byte(8'b0111_0000, ack);
    send_byte(8'h00, ack);
    busy = 1'b1;
    fork
      begin
        send_byte(8'h3C, ack);
      end
      begin
        wait (scl_pull);
        wait_q(40);
        chk(scl_pull && !scl_line, "R8 clock held", int'(scl_pull), 1);
        busy = 1'b0;
        wait_q(3);
        chk(!scl_pull, "R8 clock released", int'(scl_pull), 0);
      end
    join
    chk(ack && last_d == 8'h3C, "R8 byte intact", int'(last_d), 'h3C);
    bus_stop();

    // R11: repeated START mid-byte
    bus_start();
    send_byte(8'b0111_0000, ack);
    send_byte(8'h00, ack);
    s0 = strobes;
    send_bits(8'hFF, 4);
    bus_start();
    send_byte(8'b0111_0000, ack);
    chk(ack, "R11 address after restart", int'(ack), 1);
    send_byte(8'h20, ack);
    chk(ack && last_c && last_d == 8'h20, "R11 command after restart", int'(last_d), 'h20);
    chk(strobes - s0 == 1, "R11 partial byte dropped", strobes - s0, 1);
    bus_stop();

    // R11: after STOP, bytes without a START are ignored
    scl_m = 1'b0; wait_q(Q);
    send_byte(8'b0111_0000, ack);
    chk(!ack, "R11 idle after stop", int'(ack), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R11 idle second byte", int'(ack), 0);
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 180000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule